// File: doc/BRIEF.md
# Window Watchdog Timer with Early Warning

The block is a windowed watchdog for a peripheral bus. A down-counter is decremented at a slow rate taken from the bus clock. The rate comes from a fixed power-of-two predivider followed by a selectable power-of-two prescaler. Software must reload the counter inside a time window. A reload that comes too early raises a reset request. Letting the counter run down so that its top bit clears also raises one. So does loading a value whose top bit is already clear.

When the counter reaches the value just above the reset threshold, a warning flag is set. An interrupt can be enabled so that software gets notice before the reset. The enable bit for the reset and the enable bit for the interrupt are both sticky: software can set them, and only a block reset clears them. The counter keeps running whether or not the reset is enabled.

Registers are reached through a single-cycle write strobe and a combinational read port. There are three word registers. Unused bits read as zero.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control reads 0x0000007F (count 0x7F, arm 0), config reads 0x0000007F (window 0x7F, rate code 0, interrupt enable 0), status reads 0, and both outputs are low.
- R2: The 7-bit count (control bits 6:0) drops by one, wrapping 0x00 to 0x7F, on the clock edge that ends each period of PREDIV x 2^code clocks. Periods are counted from reset release, and code is config bits 10:8. The count runs whether or not the block is armed.
- R3: The arm bit (control bit 7) is set by writing 1 to it. Writing 0 leaves it set, and only reset clears it.
- R4: While armed, a decrement from 0x40 to 0x3F makes wdg_rst_o high for exactly the one cycle after that edge. While unarmed, the same decrement gives no pulse.
- R5: A control write whose count has bit 6 clear gives a one-cycle pulse. This applies when the block is armed before the write or when the same write sets the arm bit.
- R6: When the block is already armed, a control write made while the current count is greater than the window (config bits 6:0) gives a one-cycle pulse. A write made while the count is equal to or below the window gives no pulse.
- R7: The warning flag (status bit 0) is set on the edge where the count becomes 0x40, whatever the interrupt enable holds. A status write with bit 0 = 0 clears it, and one with bit 0 = 1 leaves it unchanged. A set on the same edge wins over a clear.
- R8: The interrupt enable (config bit 12) is sticky, cleared only by reset. warn_irq_o is high exactly when both the enable and the flag are set.
- R9: Control, config and status sit at byte offsets 0x0, 0x4 and 0x8. Offset 0xC reads zero and ignores writes, and all unused bits read zero.
- R10: A control write on the same edge as a decrement loads the written count, and that edge does not decrement it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| wdg_rst_o | output | 1 | One-cycle system reset request |
| warn_irq_o | output | 1 | Early-warning interrupt |

## Verification
Directed sequences first walk the count through its full range while unarmed. This shows that the decrement rate follows the rate code and that the warning flag rises without any reset. The block is then armed and reloads are placed at three points: with the count exactly on the window, one cycle later with the count above it, and with a value whose top bit is clear. Together these separate the early-reload cause, the low-value cause and the boundary case. A free run-down then isolates the rollover cause. A reload timed onto a decrement edge shows that the write takes priority. A long seeded random phase then mixes writes to every offset, including the unused one, with idle cycles. A cycle-level model in the bench predicts every output and register value, which catches stray pulses and lost or spurious flag changes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned BUS_AW = 4;
  localparam int unsigned BUS_DW = 32;

  // word index = addr[3:2]
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CFG  = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;

  localparam int unsigned CFG_SEL_LSB = 8;
  localparam int unsigned CFG_IE_BIT  = 12;
  localparam int unsigned STAT_FLAG_BIT = 0;

  typedef struct packed {
    logic ctrl;
    logic cfg;
    logic stat;
  } wdg_we_t;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned PREDIV = 4096,
  parameter int unsigned SEL_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PD_W   = $clog2(PREDIV);
  localparam int unsigned MAX_SH = (1 << SEL_W) - 1;
  localparam int unsigned DIV_W  = PD_W + MAX_SH;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // free-running: wrap period is a multiple of every selectable period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    int unsigned sh;
    sh   = PD_W + int'(sel_i);
    mask = ~({DIV_W{1'b1}} << sh);
  end

  assign tick_o = ((div_q & mask) == mask);
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ld_arm_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             arm_o,
  output logic             rst_req_o,
  output logic             warn_set_o
);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] PRE_TH = THRESH + 1'b1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic arm_q, arm_eff;
  logic req_q, early_ld, low_ld, roll;

  assign arm_eff  = arm_q | (ld_i & ld_arm_i);
  assign early_ld = ld_i & arm_q & (cnt_q > win_i);
  assign low_ld   = ld_i & arm_eff & ~ld_val_i[CNT_W-1];
  assign roll     = tick_i & ~ld_i & arm_q & (cnt_q == THRESH);
  assign warn_set_o = tick_i & ~ld_i & (cnt_q == PRE_TH);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)        cnt_d = ld_val_i;
    else if (tick_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      arm_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_eff;
      req_q <= early_ld | low_ld | roll;
    end
  end

  assign cnt_o     = cnt_q;
  assign arm_o     = arm_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              arm_i,
  input  logic              warn_set_i,
  output logic              ld_o,
  output logic [CNT_W-1:0]  ld_val_o,
  output logic              ld_arm_o,
  output logic [CNT_W-1:0]  win_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic [BUS_DW-1:0] rdata_o
);
  wdg_we_t we;
  logic [CNT_W-1:0] win_q;
  logic [SEL_W-1:0] sel_q;
  logic ie_q, flag_q, flag_d;
  logic unused_bits;

  assign we.ctrl = wr_i & (addr_i[3:2] == IDX_CTRL);
  assign we.cfg  = wr_i & (addr_i[3:2] == IDX_CFG);
  assign we.stat = wr_i & (addr_i[3:2] == IDX_STAT);

  assign ld_o     = we.ctrl;
  assign ld_val_o = wdata_i[CNT_W-1:0];
  assign ld_arm_o = wdata_i[CNT_W];

  always_comb begin
    flag_d = flag_q;
    if (warn_set_i)                         flag_d = 1'b1;
    else if (we.stat && !wdata_i[STAT_FLAG_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '1;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (we.cfg) begin
        win_q <= wdata_i[CNT_W-1:0];
        sel_q <= wdata_i[CFG_SEL_LSB +: SEL_W];
        ie_q  <= ie_q | wdata_i[CFG_IE_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i[3:2])
      IDX_CTRL: begin
        rdata_o[CNT_W-1:0] = cnt_i;
        rdata_o[CNT_W]     = arm_i;
      end
      IDX_CFG: begin
        rdata_o[CNT_W-1:0]              = win_q;
        rdata_o[CFG_SEL_LSB +: SEL_W]   = sel_q;
        rdata_o[CFG_IE_BIT]             = ie_q;
      end
      IDX_STAT: rdata_o[STAT_FLAG_BIT] = flag_q;
      default:  rdata_o = '0;
    endcase
  end

  assign unused_bits = ^{addr_i[1:0], wdata_i};

  assign win_o  = win_q;
  assign sel_o  = sel_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned PREDIV = 4096,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned SEL_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        wdg_rst_o,
  output logic        warn_irq_o
);
  logic             tick;
  logic             ld, ld_arm, warn_set;
  logic [CNT_W-1:0] ld_val, cnt, win;
  logic [SEL_W-1:0] sel;
  logic             arm, ie, flag;

  wdg_tick_gen #(.PREDIV(PREDIV), .SEL_W(SEL_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .tick_o(tick)
  );

  wdg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .ld_i      (ld),
    .ld_val_i  (ld_val),
    .ld_arm_i  (ld_arm),
    .win_i     (win),
    .cnt_o     (cnt),
    .arm_o     (arm),
    .rst_req_o (wdg_rst_o),
    .warn_set_o(warn_set)
  );

  wdg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .cnt_i     (cnt),
    .arm_i     (arm),
    .warn_set_i(warn_set),
    .ld_o      (ld),
    .ld_val_o  (ld_val),
    .ld_arm_o  (ld_arm),
    .win_o     (win),
    .sel_o     (sel),
    .ie_o      (ie),
    .flag_o    (flag),
    .rdata_o   (bus_rdata_o)
  );

  assign warn_irq_o = ie & flag;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [3:0]       addr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] win_i,
  input logic             arm_i,
  input logic             ie_i,
  input logic             flag_i,
  input logic             rst_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << (CNT_W - 1);

  logic ctrl_wr;
  assign ctrl_wr = wr_i & (addr_i[3:2] == 2'd0);

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_i) && !$past(ctrl_wr)) |-> (cnt_i == CNT_W'($past(cnt_i) - 1'b1)));

  // R3
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> arm_i);

  // R4
  rst_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> arm_i);

  // R6
  early_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && arm_i && (cnt_i > win_i)) |=> rst_o);

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> (cnt_i == THRESH));

  // R8
  ie_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_i |=> ie_i);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_i && flag_i));
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) u_wdg_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .wr_i  (bus_wr_i),
  .addr_i(bus_addr_i),
  .cnt_i (cnt),
  .win_i (win),
  .arm_i (arm),
  .ie_i  (ie),
  .flag_i(flag),
  .rst_o (wdg_rst_o),
  .irq_o (warn_irq_o)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PREDIV = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdg_rst, warn_irq;

  win_watchdog #(.PREDIV(PREDIV)) u_win_watchdog (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_wr_i   (bus_wr),
    .bus_addr_i (bus_addr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .wdg_rst_o  (wdg_rst),
    .warn_irq_o (warn_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  // reference state
  int       m_edges;
  bit [6:0] m_cnt, m_win;
  bit [2:0] m_sel;
  bit       m_arm, m_ie, m_flag, m_rst;
  string    m_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a[3:2])
      2'd0: return {24'b0, m_arm, m_cnt};
      2'd1: return {19'b0, m_ie, 1'b0, m_sel, 1'b0, m_win};
      2'd2: return {31'b0, m_flag};
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_edges = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_sel = 0;
    m_arm = 0; m_ie = 0; m_flag = 0; m_rst = 0; m_tag = "R4";
  endtask

  task automatic model_edge(input bit wr, input logic [3:0] a, input logic [31:0] d);
    int  period;
    bit  tick, ld, cfgw, statw, setf, arm_eff;
    period = PREDIV << m_sel;
    m_edges++;
    tick  = (m_edges % period) == 0;
    ld    = wr && a[3:2] == 2'd0;
    cfgw  = wr && a[3:2] == 2'd1;
    statw = wr && a[3:2] == 2'd2;
    m_rst = 0; m_tag = "R4"; setf = 0;
    if (ld) begin
      arm_eff = m_arm | d[7];
      if (m_arm && m_cnt > m_win) begin m_rst = 1; m_tag = "R6"; end
      if (arm_eff && !d[6])       begin m_rst = 1; m_tag = "R5"; end
      m_cnt = d[6:0];
      m_arm = arm_eff;
    end else if (tick) begin
      if (m_arm && m_cnt == 7'h40) begin m_rst = 1; m_tag = "R4"; end
      if (m_cnt == 7'h41) setf = 1;
      m_cnt = m_cnt - 7'd1;
    end
    if (cfgw) begin
      m_win = d[6:0];
      m_sel = d[10:8];
      m_ie  = m_ie | d[12];
    end
    if (setf) m_flag = 1;
    else if (statw && !d[0]) m_flag = 0;
  endtask

  // one clock: drive, model the edge, then compare away from the edge
  task automatic step(input bit wr, input logic [3:0] a, input logic [31:0] d);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(wr, a, d);
    @(negedge clk);
    bus_wr = 0; bus_addr = 4'h0;
    #1;
    chk(wdg_rst === m_rst, m_tag, {31'b0, wdg_rst}, {31'b0, m_rst});
    chk(warn_irq === (m_ie & m_flag), "R8", {31'b0, warn_irq}, {31'b0, m_ie & m_flag});
    chk(bus_rdata === exp_read(4'h0), "R2", bus_rdata, exp_read(4'h0));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'h0, 32'h0);
  endtask

  task automatic chk_reg(input logic [3:0] a, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp_read(a), tag, bus_rdata, exp_read(a));
    bus_addr = 4'h0;
  endtask

  task automatic wait_cnt(input bit [6:0] v);
    for (int i = 0; i < 4000 && m_cnt != v; i++) idle(1);
  endtask

  initial begin : watchdog
    while (cyc < WATCHDOG_CYCLES && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wdg_rst === 1'b0 && warn_irq === 1'b0, "R1", {30'b0, wdg_rst, warn_irq}, 32'h0);
    chk_reg(4'h0, "R1");
    chk_reg(4'h4, "R1");
    chk_reg(4'h8, "R1");
    @(negedge clk);
    rst_n = 1;

    // R2 rate code 0, then code 2
    idle(40);
    step(1, 4'h4, 32'h0000_027F);
    idle(100);
    chk_reg(4'h4, "R9");

    // R4 unarmed run-down through 0x40, R7 flag with interrupt disabled, R2 wrap
    step(1, 4'h4, 32'h0000_007F);
    idle(600);
    chk_reg(4'h8, "R7");
    chk(warn_irq === 1'b0, "R8", {31'b0, warn_irq}, 32'h0);

    // R7 write 1 keeps flag, write 0 clears
    step(1, 4'h8, 32'h0000_0001);
    chk_reg(4'h8, "R7");
    step(1, 4'h8, 32'h0000_0000);
    chk_reg(4'h8, "R7");

    // R9 unused offset
    step(1, 4'hC, 32'hFFFF_FFFF);
    chk_reg(4'hC, "R9");
    chk_reg(4'h4, "R9");
    chk_reg(4'h8, "R9");

    // R3 arm and stickiness
    step(1, 4'h0, 32'h0000_007F);
    step(1, 4'h0, 32'h0000_00FF);
    step(1, 4'h0, 32'h0000_007F);
    chk_reg(4'h0, "R3");

    // R8 enable sticky
    step(1, 4'h4, 32'h0000_1050);
    step(1, 4'h4, 32'h0000_0050);
    chk_reg(4'h4, "R8");

    // R6 reload exactly at window: no pulse; above window: pulse
    wait_cnt(7'h50);
    step(1, 4'h0, 32'h0000_00FF);
    chk(wdg_rst === 1'b0, "R6", {31'b0, wdg_rst}, 32'h0);
    step(1, 4'h0, 32'h0000_00FF);
    chk(wdg_rst === 1'b1, "R6", {31'b0, wdg_rst}, 32'h1);
    idle(1);
    chk(wdg_rst === 1'b0, "R6", {31'b0, wdg_rst}, 32'h0);

    // R5 low value reload
    wait_cnt(7'h48);
    step(1, 4'h0, 32'h0000_00BF);
    chk(wdg_rst === 1'b1, "R5", {31'b0, wdg_rst}, 32'h1);

    // R4 armed rollover, R8 interrupt from flag
    step(1, 4'h8, 32'h0);
    wait_cnt(7'h40);
    chk(warn_irq === 1'b1, "R8", {31'b0, warn_irq}, 32'h1);
    chk_reg(4'h8, "R7");
    wait_cnt(7'h3F);
    chk(wdg_rst === 1'b1, "R4", {31'b0, wdg_rst}, 32'h1);

    // R10 write coincides with a decrement edge
    step(1, 4'h4, 32'h0000_037F);
    for (int i = 0; i < 2000 && ((m_edges + 1) % (PREDIV << m_sel)) != 0; i++) idle(1);
    step(1, 4'h0, 32'h0000_00F0);
    chk_reg(4'h0, "R10");
    chk(m_cnt == 7'h70, "R10", {25'b0, m_cnt}, 32'h70);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 100;
      d = $urandom;
      if (r < 3)       step(1, 4'h0, (r == 0) ? d : (d | 32'h40));
      else if (r < 5)  step(1, 4'h4, d);
      else if (r < 7)  step(1, 4'h8, d);
      else if (r < 8)  step(1, 4'hC, d);
      else             step(0, 4'h0, 32'h0);
      if (r == 50) begin
        chk_reg(4'h4, "R9");
        chk_reg(4'h8, "R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule